// File: doc/BRIEF.md
# DSI Transfer Initiation Controller

This block decides when a deserial-serial frame goes out and which word it carries. Each clock it captures a word from a parallel input bus into a snapshot register. A software-supplied alternate word sits beside that register, and a source-select input picks which of the two is the candidate word. A frame can be started in two ways. The first is an edge of an external trigger, with the edge direction selectable and the trigger gated by an enable. The second is a difference between the candidate word and the word most recently shifted out.

Once a frame starts, a simple shifter sends the word MSB first, one bit per serial clock cycle. The number of cycles comes from the frame size in the normal and timed-bus modes, and from a separate count in the multiple-transfer mode. The frame-size arithmetic and a configuration-error flag are exported. A trigger that arrives during a frame is kept pending and served afterwards.

Top module: `dsi_xfer_ctrl`

## Requirements
- R1: The snapshot register takes `pins_i` on every clock. `src_sel_i`=0 serializes the snapshot word, and `src_sel_i`=1 serializes `alt_i`.
- R2: With `trig_en_i`=0, no trigger edge starts a frame.
- R3: `trig_pol_i`=1 makes a rising trigger edge start a frame and ignores falling edges. `trig_pol_i`=0 does the opposite.
- R4: The trigger passes through a two-stage synchronizer. `busy_o` rises after the third rising clock edge that follows an enabled trigger transition.
- R5: With `cid_en_i`=1 and the block idle, a frame starts when the candidate word differs from the last shifted word. No frame starts while the two words are equal.
- R6: With `mto_en_i`=1 and `tsb_en_i`=0, a frame lasts `mcnt_i`+1 serial cycles. Cycles beyond the frame size shift out 0.
- R7: `cfg_err_o` is 1 when `mto_en_i` and `tsb_en_i` are both 1, or when `mto_en_i`=1 and `mcnt_i`+1 is less than the frame size. While `cfg_err_o` is 1 no frame starts. A count equal to the frame size is legal.
- R8: The frame size `frame_bits_o` equals `fsize_i`+1, plus 16 when `fsize_ext_i`=1.
- R9: With `tsb_en_i`=1 and `mto_en_i`=0, `sck_cnt_o` equals the frame size and `mcnt_i` has no effect.
- R10: A trigger edge seen while busy is held pending. The pending frame starts after the current one ends, so both frames are sent in full and in order.
- R11: Reset clears the last-shifted word. With `cid_en_i`=1, a nonzero candidate word therefore starts a first frame. The last-shifted word takes the transmitted word when each frame ends.
- R12: Bit i of a frame of F bits appears on `sout_o` with `bit_vld_o`=1 in the i-th busy cycle and equals word[F-1-i]. `done_o` pulses for one cycle in the cycle after the last bit, and `busy_o` is 0 in that cycle.
- R13: After reset `busy_o`, `done_o`, `bit_vld_o` and `sout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | DATA_W | Parallel input bus, captured each cycle |
| alt_i | input | DATA_W | Alternate software word |
| src_sel_i | input | 1 | 0: snapshot word, 1: alternate word |
| trig_i | input | 1 | Asynchronous hardware trigger |
| trig_en_i | input | 1 | Trigger start enable |
| trig_pol_i | input | 1 | 1: rising edge starts, 0: falling edge starts |
| cid_en_i | input | 1 | Change-in-data start enable |
| mto_en_i | input | 1 | Multiple-transfer mode |
| tsb_en_i | input | 1 | Timed-bus mode |
| mcnt_i | input | MCNT_W | Serial cycle count minus one (multiple-transfer) |
| fsize_i | input | FSZ_W | Base frame size minus one |
| fsize_ext_i | input | 1 | Adds 16 to the frame size |
| frame_bits_o | output | FB_W | Frame size in bits |
| sck_cnt_o | output | SC_W | Serial cycles per frame |
| cfg_err_o | output | 1 | Illegal configuration |
| sout_o | output | 1 | Serial data, MSB first |
| bit_vld_o | output | 1 | A serial bit is on `sout_o` |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
Trigger starts are due three rising edges after the trigger changes: two synchronizer stages, then the busy register. The bench changes the trigger at a falling edge and checks `busy_o` at the second and third falling edges that follow. A change of the parallel bus starts a frame two edges later, one edge for the snapshot and one for the start. The bench samples every bit at the falling edge inside each busy cycle. It checks `done_o` at the first falling edge where `busy_o` has dropped and again one cycle later. Checks that no frame starts hold `busy_o` low over a window longer than the trigger or change latency.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_PEND = 2'd1,
    START_TRIG = 2'd2,
    START_CHG  = 2'd3
  } start_src_e;
endpackage

// File: rtl/dsi_trig_sync.sv
module dsi_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pol_i,
  input  logic en_i,
  output logic edge_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], trig_i};
  end

  logic rise, fall;
  assign rise   = sync_q[1] & ~sync_q[2];
  assign fall   = ~sync_q[1] & sync_q[2];
  assign edge_o = en_i & (pol_i ? rise : fall);
endmodule

// File: rtl/dsi_cfg_calc.sv
module dsi_cfg_calc #(
  parameter int unsigned MCNT_W = 6,
  parameter int unsigned FSZ_W  = 4,
  parameter int unsigned FB_W   = 6,
  parameter int unsigned SC_W   = 7
) (
  input  logic [FSZ_W-1:0]  fsize_i,
  input  logic              fsize_ext_i,
  input  logic [MCNT_W-1:0] mcnt_i,
  input  logic              mto_en_i,
  input  logic              tsb_en_i,
  output logic [FB_W-1:0]   frame_bits_o,
  output logic [SC_W-1:0]   sck_cnt_o,
  output logic              cfg_err_o
);
  logic [SC_W-1:0] mto_cnt, frame_w;

  always_comb begin
    frame_bits_o = FB_W'(fsize_i) + FB_W'(1) + (fsize_ext_i ? FB_W'(16) : FB_W'(0));
    frame_w      = SC_W'(frame_bits_o);
    mto_cnt      = SC_W'(mcnt_i) + SC_W'(1);
    if (mto_en_i && !tsb_en_i) sck_cnt_o = mto_cnt;
    else                       sck_cnt_o = frame_w;
    cfg_err_o = mto_en_i && (tsb_en_i || (mto_cnt < frame_w));
  end
endmodule

// File: rtl/dsi_start_arb.sv
module dsi_start_arb
  import dsi_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_edge_i,
  input  logic              cid_en_i,
  input  logic [DATA_W-1:0] cur_word_i,
  input  logic [DATA_W-1:0] last_word_i,
  input  logic              busy_i,
  input  logic              cfg_err_i,
  output logic              start_o
);
  logic       pend_q;
  start_src_e src;

  always_comb begin
    src = START_NONE;
    if (!busy_i && !cfg_err_i) begin
      if (pend_q)                                    src = START_PEND;
      else if (trig_edge_i)                          src = START_TRIG;
      else if (cid_en_i && cur_word_i != last_word_i) src = START_CHG;
    end
    start_o = (src != START_NONE);
  end

  // edges during a frame wait; an edge coinciding with a start is absorbed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= 1'b0;
    else if (busy_i && trig_edge_i) pend_q <= 1'b1;
    else if (src == START_PEND)    pend_q <= 1'b0;
  end
endmodule

// File: rtl/dsi_shifter.sv
module dsi_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FB_W   = 6,
  parameter int unsigned SC_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [FB_W-1:0]   frame_bits_i,
  input  logic [SC_W-1:0]   sck_cnt_i,
  output logic              sout_o,
  output logic              bit_vld_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] last_o
);
  localparam int unsigned SH_W = $clog2(DATA_W + 1) + 1;

  logic [DATA_W-1:0] sreg_q, tx_q, last_q;
  logic [SC_W-1:0]   cnt_q;
  logic              busy_q, done_q;
  logic [SH_W-1:0]   sh_amt;

  assign sh_amt = SH_W'(DATA_W) - SH_W'(frame_bits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      tx_q   <= '0;
      last_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        sreg_q <= sreg_q << 1;
        cnt_q  <= cnt_q - SC_W'(1);
        if (cnt_q == SC_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          last_q <= tx_q;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= sck_cnt_i;
        tx_q   <= word_i;
        sreg_q <= word_i << sh_amt;
      end
    end
  end

  assign sout_o    = busy_q & sreg_q[DATA_W-1];
  assign bit_vld_o = busy_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign last_o    = last_q;
endmodule

// File: rtl/dsi_xfer_ctrl.sv
module dsi_xfer_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MCNT_W = 6,
  parameter int unsigned FSZ_W  = 4,
  localparam int unsigned FMAX  = (1 << FSZ_W) + 16,
  localparam int unsigned CMAX  = ((1 << MCNT_W) > FMAX) ? (1 << MCNT_W) : FMAX,
  localparam int unsigned FB_W  = $clog2(FMAX + 1),
  localparam int unsigned SC_W  = $clog2(CMAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pins_i,
  input  logic [DATA_W-1:0] alt_i,
  input  logic              src_sel_i,
  input  logic              trig_i,
  input  logic              trig_en_i,
  input  logic              trig_pol_i,
  input  logic              cid_en_i,
  input  logic              mto_en_i,
  input  logic              tsb_en_i,
  input  logic [MCNT_W-1:0] mcnt_i,
  input  logic [FSZ_W-1:0]  fsize_i,
  input  logic              fsize_ext_i,
  output logic [FB_W-1:0]   frame_bits_o,
  output logic [SC_W-1:0]   sck_cnt_o,
  output logic              cfg_err_o,
  output logic              sout_o,
  output logic              bit_vld_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [DATA_W-1:0] snap_q, cur_word, last_word;
  logic              trig_edge, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= pins_i;
  end

  assign cur_word = src_sel_i ? alt_i : snap_q;

  dsi_trig_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .pol_i  (trig_pol_i),
    .en_i   (trig_en_i),
    .edge_o (trig_edge)
  );

  dsi_cfg_calc #(
    .MCNT_W (MCNT_W),
    .FSZ_W  (FSZ_W),
    .FB_W   (FB_W),
    .SC_W   (SC_W)
  ) u_cfg (
    .fsize_i      (fsize_i),
    .fsize_ext_i  (fsize_ext_i),
    .mcnt_i       (mcnt_i),
    .mto_en_i     (mto_en_i),
    .tsb_en_i     (tsb_en_i),
    .frame_bits_o (frame_bits_o),
    .sck_cnt_o    (sck_cnt_o),
    .cfg_err_o    (cfg_err_o)
  );

  dsi_start_arb #(.DATA_W(DATA_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_edge_i (trig_edge),
    .cid_en_i    (cid_en_i),
    .cur_word_i  (cur_word),
    .last_word_i (last_word),
    .busy_i      (busy_o),
    .cfg_err_i   (cfg_err_o),
    .start_o     (start)
  );

  dsi_shifter #(
    .DATA_W (DATA_W),
    .FB_W   (FB_W),
    .SC_W   (SC_W)
  ) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .word_i       (cur_word),
    .frame_bits_i (frame_bits_o),
    .sck_cnt_i    (sck_cnt_o),
    .sout_o       (sout_o),
    .bit_vld_o    (bit_vld_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .last_o       (last_word)
  );
endmodule

// File: rtl/dsi_xfer_ctrl_chk.sv
module dsi_xfer_ctrl_chk #(
  parameter int unsigned FB_W = 6,
  parameter int unsigned SC_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mto_en_i,
  input logic            tsb_en_i,
  input logic [FB_W-1:0] frame_bits_o,
  input logic [SC_W-1:0] sck_cnt_o,
  input logic            cfg_err_o,
  input logic            busy_o,
  input logic            done_o
);
  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R12
  busy_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R12
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  no_start_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(cfg_err_o));

  // R9
  tsb_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsb_en_i && !mto_en_i) |-> (SC_W'(frame_bits_o) == sck_cnt_o && !cfg_err_o));
endmodule

bind dsi_xfer_ctrl dsi_xfer_ctrl_chk #(
  .FB_W (FB_W),
  .SC_W (SC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mto_en_i     (mto_en_i),
  .tsb_en_i     (tsb_en_i),
  .frame_bits_o (frame_bits_o),
  .sck_cnt_o    (sck_cnt_o),
  .cfg_err_o    (cfg_err_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/tb_dsi_xfer_ctrl.sv
module tb_dsi_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins, alt;
  logic        src_sel, trig, trig_en, trig_pol, cid_en, mto_en, tsb_en, fsize_ext;
  logic [5:0]  mcnt;
  logic [3:0]  fsize;
  logic [5:0]  frame_bits;
  logic [6:0]  sck_cnt;
  logic        cfg_err, sout, bit_vld, busy, done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  dsi_xfer_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .alt_i(alt), .src_sel_i(src_sel),
    .trig_i(trig), .trig_en_i(trig_en), .trig_pol_i(trig_pol), .cid_en_i(cid_en),
    .mto_en_i(mto_en), .tsb_en_i(tsb_en), .mcnt_i(mcnt), .fsize_i(fsize),
    .fsize_ext_i(fsize_ext), .frame_bits_o(frame_bits), .sck_cnt_o(sck_cnt),
    .cfg_err_o(cfg_err), .sout_o(sout), .bit_vld_o(bit_vld), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    pins = 32'h0; alt = 32'h0000_00A5; src_sel = 1'b1;
    trig = 1'b0; trig_en = 1'b1; trig_pol = 1'b1; cid_en = 1'b0;
    mto_en = 1'b0; tsb_en = 1'b0; mcnt = 6'd0; fsize = 4'd7; fsize_ext = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
  endtask

  // expected serial stream for word w, frame f bits, n cycles (first bit in MSB of result)
  function automatic logic [63:0] exp_bits(input logic [31:0] w, input int f, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[62:0], (i < f) ? w[f-1-i] : 1'b0};
    return r;
  endfunction

  // waits for a frame, collects it, checks length, bits and the done pulse
  task automatic expect_frame(input string req, input logic [31:0] w, input int f, input int n);
    int t = 0;
    int cnt = 0;
    logic [63:0] got = '0;
    while (!busy && t < 60) begin @(negedge clk); t++; end
    chk(req, "frame started", busy, 1'b1);
    while (busy && cnt < 80) begin
      got = {got[62:0], sout};
      cnt++;
      @(negedge clk);
    end
    chk(req, "bit count", cnt, n);
    chk(req, "bit stream", got, exp_bits(w, f, n));
    chk("R12", "done after last bit", done, 1'b1);
    @(negedge clk);
    chk("R12", "done single cycle", done, 1'b0);
  endtask

  task automatic expect_idle(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); seen = seen | busy; end
    chk(req, "no frame started", seen, 1'b0);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R13", "busy after reset", busy, 1'b0);
    chk("R13", "done after reset", done, 1'b0);
    chk("R13", "valid/sout after reset", {bit_vld, sout}, 2'b00);
    chk("R7", "no error by default", cfg_err, 1'b0);
    chk("R8", "frame size 8", frame_bits, 6'd8);
  endtask

  task automatic t_rise_latency();
    reset_dut();
    pins = 32'h0000_0033;
    trig = 1'b1;
    wait_neg(2);
    chk("R4", "not busy after two edges", busy, 1'b0);
    wait_neg(1);
    chk("R4", "busy after third edge", busy, 1'b1);
    expect_frame("R1", 32'h0000_00A5, 8, 8);
  endtask

  task automatic t_polarity();
    reset_dut();
    trig_pol = 1'b0;
    trig = 1'b1;
    expect_idle("R3", 8);
    alt = 32'h0000_005C;
    trig = 1'b0;
    expect_frame("R3", 32'h0000_005C, 8, 8);
    reset_dut();
    trig = 1'b1;
    wait_neg(20);
    trig = 1'b0;
    expect_idle("R3", 8);
  endtask

  task automatic t_disabled();
    reset_dut();
    trig_en = 1'b0;
    trig = 1'b1;
    expect_idle("R2", 10);
  endtask

  task automatic t_change();
    reset_dut();
    src_sel = 1'b0; alt = 32'hFFFF_FFFF; trig_en = 1'b0; cid_en = 1'b1;
    pins = 32'h0000_00A6;
    expect_frame("R11", 32'h0000_00A6, 8, 8);
    expect_idle("R5", 12);
    pins = 32'h0000_003C;
    wait_neg(1);
    chk("R5", "not busy one edge after change", busy, 1'b0);
    wait_neg(1);
    chk("R5", "busy two edges after change", busy, 1'b1);
    expect_frame("R5", 32'h0000_003C, 8, 8);
    alt = 32'h0000_003C; src_sel = 1'b1;
    expect_idle("R1", 10);
    alt = 32'h0000_0081;
    expect_frame("R1", 32'h0000_0081, 8, 8);
  endtask

  task automatic t_mto();
    reset_dut();
    mto_en = 1'b1; mcnt = 6'd11; alt = 32'h0000_00F3;
    wait_neg(1);
    chk("R6", "clock count", sck_cnt, 7'd12);
    trig = 1'b1;
    expect_frame("R6", 32'h0000_00F3, 8, 12);
  endtask

  task automatic t_cfg_err();
    reset_dut();
    mto_en = 1'b1; mcnt = 6'd5;
    wait_neg(1);
    chk("R7", "count below frame", cfg_err, 1'b1);
    trig = 1'b1;
    expect_idle("R7", 10);
    mcnt = 6'd20; tsb_en = 1'b1;
    wait_neg(1);
    chk("R7", "both modes set", cfg_err, 1'b1);
    tsb_en = 1'b0; mcnt = 6'd7; trig = 1'b0;
    wait_neg(1);
    chk("R7", "count equal to frame legal", cfg_err, 1'b0);
    expect_idle("R7", 6);
    trig = 1'b1;
    expect_frame("R7", 32'h0000_00A5, 8, 8);
  endtask

  task automatic t_ext_tsb();
    reset_dut();
    fsize = 4'd3; fsize_ext = 1'b1; alt = 32'h000A_BCDE;
    wait_neg(1);
    chk("R8", "extended frame size", frame_bits, 6'd20);
    trig = 1'b1;
    expect_frame("R8", 32'h000A_BCDE, 20, 20);
    reset_dut();
    tsb_en = 1'b1; mcnt = 6'd2; fsize = 4'd11; alt = 32'h0000_9A5B;
    wait_neg(1);
    chk("R9", "count from frame", sck_cnt, 7'd12);
    chk("R9", "no error", cfg_err, 1'b0);
    trig = 1'b1;
    expect_frame("R9", 32'h0000_9A5B, 12, 12);
  endtask

  task automatic t_pending();
    reset_dut();
    fsize = 4'd15; alt = 32'h0000_C3A5;
    fork
      begin
        trig = 1'b1; wait_neg(6);
        trig = 1'b0; wait_neg(3);
        trig = 1'b1;
      end
      begin
        expect_frame("R10", 32'h0000_C3A5, 16, 16);
        expect_frame("R10", 32'h0000_C3A5, 16, 16);
      end
    join
    expect_idle("R10", 8);
  endtask

  initial begin
    t_reset();
    t_rise_latency();
    t_polarity();
    t_disabled();
    t_change();
    t_mto();
    t_cfg_err();
    t_ext_tsb();
    t_pending();
    finish_run();
  end
endmodule